// File: doc/BRIEF.md
# Programmable Compressed Instruction Expander

This block widens short compressed instruction parcels into full 36-bit instructions. The expansion is not fixed decode logic. Each compressed form is an index into a lookup table that software fills in, so the meaning of every short code can be changed at run time. There are two tables. A 64-entry table serves 12-bit parcels and a 1024-entry table serves 16-bit parcels. Every entry holds a 36-bit instruction.

Fetch hands over one parcel per cycle with a two-bit length tag. One clock later the block presents the expanded instruction with a valid flag. Full-width 36-bit parcels go through unchanged with the same latency. 20-bit parcels are not handled here and are flagged as unsupported.

The tables are loaded through a store port that sees ordinary store traffic. The two highest 16 KB pages of a 32-bit address space hold the tables. The lower of these pages holds the 12-bit table and the top page holds the 16-bit table. Each entry takes one 8-byte slot. After reset every entry holds an illegal-instruction pattern, so a code that has not been loaded traps.

Top module: `cx_expander`

## Requirements
- R1: After reset `expValid` and `expUnsup` are low, and every entry of both tables reads as the illegal pattern 36'hFFFFFFFFF.
- R2: A store with `stValid` high and an 8-byte aligned address (`stAddr[2:0]` zero) writes `stData` into one entry. Slot index = `stAddr[13:3]`. `stAddr[31:14]` = 18'h3FFFE (base 32'hFFFF8000) selects the 12-bit table and 18'h3FFFF (base 32'hFFFFC000) selects the 16-bit table.
- R3: A store whose slot index is at or past the table depth (64 for the 12-bit table, 1024 for the 16-bit table) changes no entry.
- R4: A store outside the two top pages, or one that is not 8-byte aligned, changes no entry.
- R5: A parcel with tag 2'd0 (12-bit) is looked up in the 12-bit table with index `parcelBits[5:0]`. All higher parcel bits are ignored.
- R6: A parcel with tag 2'd1 (16-bit) is looked up in the 16-bit table with index `parcelBits[9:0]`. All higher parcel bits are ignored.
- R7: `expValid` equals `parcelValid` of the previous cycle. The matching `expInst` appears in that same cycle.
- R8: When a store and a lookup hit the same entry in the same cycle, the lookup returns the contents from before the store. The next lookup sees the new value.
- R9: A parcel with tag 2'd3 (36-bit) appears on `expInst` unchanged one cycle later.
- R10: A parcel with tag 2'd2 (20-bit) gives, one cycle later, `expValid` high, `expUnsup` high and `expInst` equal to the illegal pattern. `expUnsup` is low in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| parcelValid | input | 1 | A parcel is presented this cycle |
| parcelLen | input | 2 | Length tag: 0=12-bit, 1=16-bit, 2=20-bit, 3=36-bit |
| parcelBits | input | 36 | Parcel, right-aligned |
| stValid | input | 1 | A store is presented this cycle |
| stAddr | input | 32 | Store byte address |
| stData | input | 36 | Store data, one table entry |
| expValid | output | 1 | Expanded instruction valid |
| expInst | output | 36 | Expanded instruction |
| expUnsup | output | 1 | Parcel length not supported by this block |

## Verification
Every lookup result, and the unsupported flag, is due exactly one clock after the parcel is presented. The bench drives each parcel on a falling edge and reads the outputs on the next falling edge, half a cycle after the registering edge. A store updates its table on the rising edge that follows it. For that reason table contents are always checked through a lookup issued no earlier than the cycle after the store. The one deliberate exception is the same-cycle store and lookup, which must still return the old entry.

// File: rtl/cx_pkg.sv
package cx_pkg;

  typedef enum logic [1:0] {
    LEN_C12  = 2'd0,
    LEN_C16  = 2'd1,
    LEN_C20  = 2'd2,
    LEN_FULL = 2'd3
  } parcelLenE;

  typedef struct packed {
    logic      wrSmall;
    logic      wrLarge;
    logic      lkValid;
    parcelLenE lkKind;
  } cxStrobesT;

endpackage

// File: rtl/cx_ctrl.sv
module cx_ctrl
  import cx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_W      = 14,
  parameter int STRIDE_LOG2 = 3,
  parameter int SMALL_IDX_W = 6,
  parameter int LARGE_IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   parcelValid,
  input  logic [1:0]             parcelLen,
  input  logic                   stValid,
  input  logic [ADDR_W-1:0]      stAddr,
  output cxStrobesT              strb,
  output logic [LARGE_IDX_W-1:0] wrIndex
);

  localparam int TAG_W    = ADDR_W - PAGE_W;
  localparam int SLOT_W   = PAGE_W - STRIDE_LOG2;
  localparam logic [TAG_W-1:0] LARGE_TAG = '1;
  localparam logic [TAG_W-1:0] SMALL_TAG = LARGE_TAG - TAG_W'(1);
  localparam logic [SLOT_W-1:0] SMALL_DEPTH = SLOT_W'(1 << SMALL_IDX_W);
  localparam logic [SLOT_W-1:0] LARGE_DEPTH = SLOT_W'(1 << LARGE_IDX_W);

  logic [TAG_W-1:0]  pageTag;
  logic [SLOT_W-1:0] slotIdx;
  logic              aligned;

  assign pageTag = stAddr[ADDR_W-1:PAGE_W];
  assign slotIdx = stAddr[PAGE_W-1:STRIDE_LOG2];
  assign aligned = (stAddr[STRIDE_LOG2-1:0] == '0);

  always_comb begin
    strb.wrSmall = stValid && aligned && (pageTag == SMALL_TAG) && (slotIdx < SMALL_DEPTH);
    strb.wrLarge = stValid && aligned && (pageTag == LARGE_TAG) && (slotIdx < LARGE_DEPTH);
    strb.lkValid = parcelValid;
    strb.lkKind  = parcelLenE'(parcelLen);
    wrIndex      = slotIdx[LARGE_IDX_W-1:0];
  end

  // R4
  misaligned_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stAddr[STRIDE_LOG2-1:0] != '0) |-> !(strb.wrSmall || strb.wrLarge));

  // R2
  one_table_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrSmall, strb.wrLarge}));

endmodule

// File: rtl/cx_datapath.sv
module cx_datapath
  import cx_pkg::*;
#(
  parameter int                INST_W       = 36,
  parameter int                SMALL_IDX_W  = 6,
  parameter int                LARGE_IDX_W  = 10,
  parameter logic [INST_W-1:0] ILLEGAL_INST = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cxStrobesT              strb,
  input  logic [LARGE_IDX_W-1:0] wrIndex,
  input  logic [INST_W-1:0]      wrData,
  input  logic [INST_W-1:0]      parcelBits,
  output logic                   expValid,
  output logic [INST_W-1:0]      expInst,
  output logic                   expUnsup
);

  localparam int SMALL_DEPTH = 1 << SMALL_IDX_W;
  localparam int LARGE_DEPTH = 1 << LARGE_IDX_W;

  logic [INST_W-1:0] smallTbl [SMALL_DEPTH];
  logic [INST_W-1:0] largeTbl [LARGE_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SMALL_DEPTH; i++) smallTbl[i] <= ILLEGAL_INST;
    end else if (strb.wrSmall) begin
      smallTbl[wrIndex[SMALL_IDX_W-1:0]] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LARGE_DEPTH; i++) largeTbl[i] <= ILLEGAL_INST;
    end else if (strb.wrLarge) begin
      largeTbl[wrIndex] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expUnsup <= 1'b0;
      expInst  <= ILLEGAL_INST;
    end else begin
      expValid <= strb.lkValid;
      expUnsup <= strb.lkValid && (strb.lkKind == LEN_C20);
      if (strb.lkValid) begin
        unique case (strb.lkKind)
          LEN_C12:  expInst <= smallTbl[parcelBits[SMALL_IDX_W-1:0]];
          LEN_C16:  expInst <= largeTbl[parcelBits[LARGE_IDX_W-1:0]];
          LEN_FULL: expInst <= parcelBits;
          default:  expInst <= ILLEGAL_INST;
        endcase
      end
    end
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.lkValid |=> expValid);

  // R7
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lkValid |=> !expValid);

  // R9
  passthrough_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lkValid && strb.lkKind == LEN_FULL) |=> (expInst == $past(parcelBits)));

  // R10
  unsup_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lkValid && strb.lkKind == LEN_C20) |=> (expUnsup && expInst == ILLEGAL_INST));

  // R10
  unsup_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    expUnsup |-> expValid);

endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                INST_W       = 36,
  parameter int                PAGE_W       = 14,
  parameter int                STRIDE_LOG2  = 3,
  parameter int                SMALL_IDX_W  = 6,
  parameter int                LARGE_IDX_W  = 10,
  parameter logic [INST_W-1:0] ILLEGAL_INST = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              parcelValid,
  input  logic [1:0]        parcelLen,
  input  logic [INST_W-1:0] parcelBits,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [INST_W-1:0] stData,
  output logic              expValid,
  output logic [INST_W-1:0] expInst,
  output logic              expUnsup
);

  cxStrobesT              strb;
  logic [LARGE_IDX_W-1:0] wrIndex;

  cx_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .STRIDE_LOG2(STRIDE_LOG2),
    .SMALL_IDX_W(SMALL_IDX_W), .LARGE_IDX_W(LARGE_IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .parcelValid(parcelValid), .parcelLen(parcelLen),
    .stValid(stValid), .stAddr(stAddr), .strb(strb), .wrIndex(wrIndex)
  );

  cx_datapath #(
    .INST_W(INST_W), .SMALL_IDX_W(SMALL_IDX_W), .LARGE_IDX_W(LARGE_IDX_W),
    .ILLEGAL_INST(ILLEGAL_INST)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIndex(wrIndex), .wrData(stData),
    .parcelBits(parcelBits), .expValid(expValid), .expInst(expInst), .expUnsup(expUnsup)
  );

endmodule

// File: tb/cx_expander_bench.sv
module cx_expander_bench;

  localparam logic [35:0] ILL        = 36'hFFFFFFFFF;
  localparam logic [31:0] SMALL_BASE = 32'hFFFF8000;
  localparam logic [31:0] LARGE_BASE = 32'hFFFFC000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        parcelValid = 1'b0;
  logic [1:0]  parcelLen = 2'd0;
  logic [35:0] parcelBits = '0;
  logic        stValid = 1'b0;
  logic [31:0] stAddr = '0;
  logic [35:0] stData = '0;
  logic        expValid;
  logic [35:0] expInst;
  logic        expUnsup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cx_expander u_cx_expander (
    .clk(clk), .rstN(rstN), .parcelValid(parcelValid), .parcelLen(parcelLen),
    .parcelBits(parcelBits), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .expValid(expValid), .expInst(expInst), .expUnsup(expUnsup)
  );

  task automatic checkOut(input string req, input logic v, input logic [35:0] inst, input logic u);
    checks++;
    if (expValid !== v || expInst !== inst || expUnsup !== u) begin
      errors++;
      $display("FAIL %s: got valid=%b inst=%h unsup=%b, expected valid=%b inst=%h unsup=%b",
               req, expValid, expInst, expUnsup, v, inst, u);
    end
  endtask

  task automatic doStore(input logic [31:0] a, input logic [35:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic lookup(input string req, input logic [1:0] len, input logic [35:0] bits,
                        input logic [35:0] expInstV, input logic expU);
    @(negedge clk);
    parcelValid = 1'b1; parcelLen = len; parcelBits = bits;
    @(negedge clk);
    parcelValid = 1'b0;
    checkOut(req, 1'b1, expInstV, expU);
  endtask

  task automatic testReset();
    checkOut("R1 outputs", 1'b0, ILL, 1'b0);
    lookup("R1 small unloaded", 2'd0, 36'h0000_0005, ILL, 1'b0);
    lookup("R1 large unloaded", 2'd1, 36'h0000_03E8, ILL, 1'b0);
  endtask

  task automatic testSmall();
    doStore(SMALL_BASE + 32'd5 * 8, 36'h1_2345_6789);
    lookup("R2 R5 small idx5 group bits set", 2'd0, 36'hF_FFFF_FFC5, 36'h1_2345_6789, 1'b0);
    doStore(SMALL_BASE + 32'd63 * 8, 36'hA_0000_003F);
    lookup("R5 small idx63", 2'd0, 36'h0000_003F, 36'hA_0000_003F, 1'b0);
  endtask

  task automatic testLarge();
    doStore(LARGE_BASE + 32'd1023 * 8, 36'h5_5AA5_5AA5);
    lookup("R2 R6 large idx1023", 2'd1, 36'h0000_A3FF, 36'h5_5AA5_5AA5, 1'b0);
    lookup("R6 small table not touched", 2'd0, 36'h0000_003F, 36'hA_0000_003F, 1'b0);
  endtask

  task automatic testRange();
    doStore(SMALL_BASE + 32'd64 * 8, 36'h0_DEAD_0001);
    lookup("R3 small idx64 dropped", 2'd0, 36'h0000_0000, ILL, 1'b0);
    doStore(LARGE_BASE + 32'd1024 * 8, 36'h0_DEAD_0002);
    lookup("R3 large idx1024 dropped", 2'd1, 36'h0000_0000, ILL, 1'b0);
  endtask

  task automatic testOutside();
    doStore(32'hFFFF0000 + 32'd5 * 8, 36'h0_BAD0_0001);
    lookup("R4 outside page dropped", 2'd0, 36'h0000_0005, 36'h1_2345_6789, 1'b0);
    doStore(SMALL_BASE + 32'd5 * 8 + 32'd4, 36'h0_BAD0_0002);
    lookup("R4 misaligned dropped", 2'd0, 36'h0000_0005, 36'h1_2345_6789, 1'b0);
  endtask

  task automatic testPassUnsup();
    lookup("R9 full-width pass", 2'd3, 36'hC_3A5A_F00D, 36'hC_3A5A_F00D, 1'b0);
    lookup("R10 20-bit unsupported", 2'd2, 36'h0_000A_BCDE, ILL, 1'b1);
  endtask

  task automatic testCollision();
    @(negedge clk);
    stValid = 1'b1; stAddr = SMALL_BASE + 32'd5 * 8; stData = 36'h7_7777_0005;
    parcelValid = 1'b1; parcelLen = 2'd0; parcelBits = 36'h0000_0005;
    @(negedge clk);
    stValid = 1'b0; parcelValid = 1'b0;
    checkOut("R8 same-cycle old value", 1'b1, 36'h1_2345_6789, 1'b0);
    lookup("R8 next lookup new value", 2'd0, 36'h0000_0005, 36'h7_7777_0005, 1'b0);
  endtask

  task automatic testIdle();
    lookup("R7 valid one cycle", 2'd3, 36'h0_0000_0001, 36'h0_0000_0001, 1'b0);
    @(negedge clk);
    checkOut("R7 idle drops valid", 1'b0, 36'h0_0000_0001, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSmall();
    testLarge();
    testRange();
    testOutside();
    testPassUnsup();
    testCollision();
    testIdle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule